// File: doc/BRIEF.md
# SMBus Automatic Packet Error Code Engine

This block runs next to the byte shifter of an SMBus host controller and keeps a running CRC-8 over every byte that crosses the wire in a transaction, address bytes included. The shifter raises a one-cycle byte strobe for each byte it sends or receives. It pulses a start strobe on every START or repeated START, which clears the running code.

When the automatic mode input is high on a write cycle, the block offers the computed code as the byte to append after the final data byte. The value held in the software PEC register is never offered in this mode. On a read cycle in automatic mode, the byte flagged as last is taken as the received packet error code and compared against the running code. A mismatch sets two sticky error flags, a general device-error flag and a dedicated CRC-error flag. Each flag is cleared by its own write-one-to-clear strobe.

Software is not allowed to turn on the manual PEC enable and the automatic mode together. The block reports that combination as a configuration error and makes no read check while it persists.

Top module: `smb_pec_engine`

## Requirements
- R1: The running code is a CRC-8 with polynomial x^8+x^2+x+1 (07h), initial value 00h, processed most significant bit first. `crc_out` shows the updated value in the cycle after a `byte_vld` strobe and holds its value in cycles with neither `byte_vld` nor `txn_start`.
- R2: A `txn_start` pulse with no byte strobe sets `crc_out` to 00h in the next cycle. If `txn_start` and `byte_vld` are high in the same cycle, the byte is folded into 00h.
- R3: Every strobed byte enters the code, address bytes included. After a start, the sequence 5Ah, 01h, 02h gives B8h.
- R4: When `auto_en` is 1, `pec_out` equals `crc_out` whatever `sw_pec_val` holds. When `auto_en` is 0, `pec_out` equals `sw_pec_val`. `pec_append` is 1 exactly when `auto_en` is 1 and `rd_dir` is 0.
- R5: A strobed byte with `byte_last`=1, `rd_dir`=1 (read) and `auto_en`=1 whose value differs from the running code before that byte sets both `dev_err` and `crc_err` in the next cycle. A matching byte sets neither flag, and `crc_out` then becomes 00h.
- R6: `dev_err` and `crc_err` stay set until their own clear strobes (`dev_err_clr`, `crc_err_clr`) are pulsed. Clearing one flag leaves the other unchanged. A new mismatch in the same cycle as a clear wins.
- R7: `cfg_err` is 1 whenever `auto_en` and `sw_pec_en` are both 1. While it is 1, no read check is made and the error flags do not change.
- R8: With `auto_en`=0, a final read byte never sets an error flag.
- R9: After reset, `crc_out`, `dev_err` and `crc_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_start | input | 1 | Pulse on START or repeated START |
| byte_vld | input | 1 | One-cycle strobe for a byte on the wire |
| byte_dat | input | 8 | Byte sent or received |
| byte_last | input | 1 | Marks the final byte of a read (the received PEC) |
| rd_dir | input | 1 | 1 = read cycle, 0 = write cycle |
| auto_en | input | 1 | Automatic CRC mode |
| sw_pec_en | input | 1 | Manual PEC enable from software |
| sw_pec_val | input | 8 | Software PEC register value |
| dev_err_clr | input | 1 | Write-one-to-clear strobe for `dev_err` |
| crc_err_clr | input | 1 | Write-one-to-clear strobe for `crc_err` |
| crc_out | output | 8 | Running CRC |
| pec_out | output | 8 | Byte to append after the last write data byte |
| pec_append | output | 1 | Tells the shifter to append `pec_out` |
| cfg_err | output | 1 | Illegal mode combination |
| dev_err | output | 1 | Sticky device error |
| crc_err | output | 1 | Sticky CRC error |

## Verification
If the running code is corrupted, `crc_out` shows a wrong value one cycle after the strobe that caused it. The corruption then carries into every later byte until the next start, and it ends in a spurious or missed error on the final byte of a read. A wrong flag state appears on `dev_err` or `crc_err` in the cycle after the final byte or after a clear strobe. The bench therefore compares `crc_out` after every byte, and compares the flags after each final byte and after each clear.

// File: rtl/smb_pec_pkg.sv
// Package: shared CRC width and the single-byte CRC step function.
// Assumes MSB-first bit order and a non-reflected polynomial.
package smb_pec_pkg;
    localparam int CRC_W = 8;

    // One byte folded into the running code, one bit per loop pass.
    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0] cur,
        input logic [CRC_W-1:0] dat,
        input logic [CRC_W-1:0] poly
    );
        logic [CRC_W-1:0] c;
        c = cur ^ dat;
        for (int i = 0; i < CRC_W; i++) begin
            c = c[CRC_W-1] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/pec_crc_accum.sv
// Running CRC register. A start pulse resets the base to INIT.
// If a start pulse and a byte strobe coincide, the byte is folded into INIT.
// Assumes byte_vld is a one-cycle strobe per byte.
module pec_crc_accum
    import smb_pec_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 8'h07,
    parameter logic [CRC_W-1:0] INIT = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             vld,
    input  logic [CRC_W-1:0] dat,
    output logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] crc_base
);
    logic [CRC_W-1:0] crc_nxt;

    // Value the incoming byte is compared against and folded into.
    always_comb begin
        crc_base = clr ? INIT : crc_q;
        crc_nxt  = crc_step(crc_base, dat, POLY);
    end

    // Register update: fold on a strobe, clear on a bare start.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc_q <= INIT;
        else if (vld) crc_q <= crc_nxt;
        else if (clr) crc_q <= INIT;
    end
endmodule

// File: rtl/pec_rd_check.sv
// Read-side compare and sticky error flags.
// The device-error and CRC-error flags are built as two copies of one
// sticky cell; a set in the same cycle as a clear wins.
// Assumes chk_en is high for exactly the final read byte in a legal mode.
module pec_rd_check
    import smb_pec_pkg::*;
#(
    parameter int N_FLAGS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_en,
    input  logic [CRC_W-1:0]   rx_byte,
    input  logic [CRC_W-1:0]   exp_byte,
    input  logic [N_FLAGS-1:0] flag_clr,
    output logic [N_FLAGS-1:0] flag_q
);
    logic mismatch;

    // Compare the received code with the running code before the byte.
    always_comb mismatch = chk_en && (rx_byte != exp_byte);

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        // Sticky flag: set on mismatch, else clear on its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)           flag_q[g] <= 1'b0;
            else if (mismatch)    flag_q[g] <= 1'b1;
            else if (flag_clr[g]) flag_q[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/pec_tx_sel.sv
// Mode decode: picks the byte to append on writes and flags an illegal
// mode combination. Purely combinational.
module pec_tx_sel
    import smb_pec_pkg::*;
(
    input  logic             auto_en,
    input  logic             sw_pec_en,
    input  logic             rd_dir,
    input  logic [CRC_W-1:0] crc,
    input  logic [CRC_W-1:0] sw_val,
    output logic [CRC_W-1:0] pec_out,
    output logic             pec_append,
    output logic             cfg_err
);
    // The automatic mode always overrides the software register.
    always_comb begin
        pec_out    = auto_en ? crc : sw_val;
        pec_append = auto_en && !rd_dir;
        cfg_err    = auto_en && sw_pec_en;
    end
endmodule

// File: rtl/smb_pec_engine.sv
// Top: automatic SMBus packet error code engine.
// Keeps a CRC over all strobed bytes, offers it for appending on writes,
// checks the final read byte, and holds sticky error flags.
// Assumes the shifter strobes every wire byte except an appended write PEC.
module smb_pec_engine
    import smb_pec_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 8'h07,
    parameter logic [CRC_W-1:0] INIT = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_start,
    input  logic             byte_vld,
    input  logic [CRC_W-1:0] byte_dat,
    input  logic             byte_last,
    input  logic             rd_dir,
    input  logic             auto_en,
    input  logic             sw_pec_en,
    input  logic [CRC_W-1:0] sw_pec_val,
    input  logic             dev_err_clr,
    input  logic             crc_err_clr,
    output logic [CRC_W-1:0] crc_out,
    output logic [CRC_W-1:0] pec_out,
    output logic             pec_append,
    output logic             cfg_err,
    output logic             dev_err,
    output logic             crc_err
);
    localparam int N_FLAGS = 2;

    logic [CRC_W-1:0]   crc_base;
    logic               chk_en;
    logic [N_FLAGS-1:0] flags;

    pec_crc_accum #(.POLY(POLY), .INIT(INIT)) u_accum (
        .clk(clk), .rst_n(rst_n), .clr(txn_start), .vld(byte_vld),
        .dat(byte_dat), .crc_q(crc_out), .crc_base(crc_base)
    );

    pec_tx_sel u_sel (
        .auto_en(auto_en), .sw_pec_en(sw_pec_en), .rd_dir(rd_dir),
        .crc(crc_out), .sw_val(sw_pec_val), .pec_out(pec_out),
        .pec_append(pec_append), .cfg_err(cfg_err)
    );

    // Check only the final read byte in legal automatic mode.
    always_comb chk_en = byte_vld && byte_last && rd_dir && auto_en && !cfg_err;

    pec_rd_check #(.N_FLAGS(N_FLAGS)) u_chk (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .rx_byte(byte_dat),
        .exp_byte(crc_base), .flag_clr({crc_err_clr, dev_err_clr}),
        .flag_q(flags)
    );

    // Flag fan-out: bit 0 device error, bit 1 CRC error.
    always_comb begin
        dev_err = flags[0];
        crc_err = flags[1];
    end
endmodule

// File: rtl/smb_pec_engine_chk.sv
// Checker bound to the top: temporal properties over ports.
module smb_pec_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txn_start,
    input logic       byte_vld,
    input logic       auto_en,
    input logic       dev_err_clr,
    input logic       crc_err_clr,
    input logic [7:0] crc_out,
    input logic [7:0] pec_out,
    input logic       cfg_err,
    input logic       dev_err,
    input logic       crc_err
);
    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!txn_start && !byte_vld) |=> $stable(crc_out)); // R1
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && !byte_vld) |=> (crc_out == 8'h00)); // R2
    AST_AUTO_PEC_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        auto_en |-> (pec_out == crc_out)); // R4
    AST_ERR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> $rose(dev_err) || $past(dev_err)); // R5
    AST_CRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !crc_err_clr) |=> crc_err); // R6
    AST_DEV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_err && !dev_err_clr) |=> dev_err); // R6
    AST_NO_CHECK_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !crc_err) |=> !crc_err); // R7
endmodule

bind smb_pec_engine smb_pec_engine_chk u_chk_bind (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .byte_vld(byte_vld),
    .auto_en(auto_en), .dev_err_clr(dev_err_clr), .crc_err_clr(crc_err_clr),
    .crc_out(crc_out), .pec_out(pec_out), .cfg_err(cfg_err),
    .dev_err(dev_err), .crc_err(crc_err)
);

// File: tb/smb_pec_engine_tb.sv
// Bench: directed corner cases plus seeded random transactions.
module smb_pec_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 0, byte_vld = 0, byte_last = 0, rd_dir = 0;
    logic       auto_en = 0, sw_pec_en = 0, dev_err_clr = 0, crc_err_clr = 0;
    logic [7:0] byte_dat = 0, sw_pec_val = 0;
    logic [7:0] crc_out, pec_out;
    logic       pec_append, cfg_err, dev_err, crc_err;

    int errs = 0;
    int checks = 0;
    logic [7:0] m_crc;   // bench model of the running code
    logic       m_dev, m_crcf;

    always #2.5 clk = ~clk;   // 200 MHz

    smb_pec_engine dut_i (.*);

    // Reference CRC-8 step, 07h, MSB first.
    function automatic logic [7:0] ref_step(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] x;
        x = c ^ b;
        for (int k = 0; k < 8; k++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        return x;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One byte strobe; samples outputs at the following falling edge.
    task automatic send(input logic [7:0] b, input logic last, input logic start);
        logic chk_now;
        @(negedge clk);
        byte_dat = b; byte_vld = 1; byte_last = last; txn_start = start;
        if (start) m_crc = 8'h00;
        chk_now = last && rd_dir && auto_en && !(auto_en && sw_pec_en);
        if (chk_now && (b != m_crc)) begin m_dev = 1; m_crcf = 1; end
        m_crc = ref_step(m_crc, b);
        @(negedge clk);
        byte_vld = 0; byte_last = 0; txn_start = 0;
    endtask

    task automatic start_only();
        @(negedge clk); txn_start = 1; m_crc = 8'h00;
        @(negedge clk); txn_start = 0;
    endtask

    task automatic clear_both();
        @(negedge clk); dev_err_clr = 1; crc_err_clr = 1; m_dev = 0; m_crcf = 0;
        @(negedge clk); dev_err_clr = 0; crc_err_clr = 0;
    endtask

    initial begin
        #1_000_000;
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        m_crc = 0; m_dev = 0; m_crcf = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9 crc reset", crc_out, 8'h00);
        chk("R9 flags reset", {6'b0, dev_err, crc_err}, 8'h00);

        // R3: reference sequence, write cycle, automatic mode.
        auto_en = 1; rd_dir = 0; sw_pec_val = 8'h3C;
        send(8'h5A, 0, 1); send(8'h01, 0, 0); send(8'h02, 0, 0);
        chk("R3 reference B8", crc_out, 8'hB8);
        chk("R4 auto pec_out", pec_out, 8'hB8);
        chk("R4 append write", {7'b0, pec_append}, 8'h01);
        // R1: hold without strobe.
        repeat (3) @(negedge clk);
        chk("R1 hold", crc_out, 8'hB8);
        // R4: manual mode passes software value, no append.
        auto_en = 0; #0;
        chk("R4 manual pec_out", pec_out, 8'h3C);
        chk("R4 no append", {7'b0, pec_append}, 8'h00);
        // R2: bare start clears.
        start_only();
        chk("R2 start clears", crc_out, 8'h00);

        // R5: matching read.
        auto_en = 1; rd_dir = 1;
        send(8'h5B, 0, 1); send(8'h77, 0, 0); send(m_crc, 1, 0);
        chk("R5 match crc zero", crc_out, 8'h00);
        chk("R5 match no flags", {6'b0, dev_err, crc_err}, 8'h00);
        // R5: mismatching read.
        send(8'h5B, 0, 1); send(m_crc ^ 8'h10, 1, 0);
        chk("R5 mismatch flags", {6'b0, dev_err, crc_err}, 8'h03);
        // R6: separate clears.
        @(negedge clk); dev_err_clr = 1; m_dev = 0;
        @(negedge clk); dev_err_clr = 0;
        chk("R6 dev cleared crc kept", {6'b0, dev_err, crc_err}, 8'h01);
        repeat (2) @(negedge clk);
        chk("R6 sticky", {6'b0, dev_err, crc_err}, 8'h01);
        clear_both();
        chk("R6 both cleared", {6'b0, dev_err, crc_err}, 8'h00);
        // R6: set wins over clear in same cycle.
        send(8'h11, 0, 1);
        @(negedge clk);
        byte_dat = ~m_crc; byte_vld = 1; byte_last = 1;
        dev_err_clr = 1; crc_err_clr = 1;
        m_crc = ref_step(m_crc, ~m_crc); m_dev = 1; m_crcf = 1;
        @(negedge clk);
        byte_vld = 0; byte_last = 0; dev_err_clr = 0; crc_err_clr = 0;
        chk("R6 set wins", {6'b0, dev_err, crc_err}, 8'h03);
        clear_both();
        // R7: illegal combination, no check.
        sw_pec_en = 1; #0;
        chk("R7 cfg_err", {7'b0, cfg_err}, 8'h01);
        send(8'h22, 0, 1); send(m_crc ^ 8'hFF, 1, 0);
        chk("R7 no flags", {6'b0, dev_err, crc_err}, 8'h00);
        sw_pec_en = 0;
        // R8: manual mode, wrong final read byte ignored.
        auto_en = 0;
        send(8'h33, 0, 1); send(m_crc ^ 8'h01, 1, 0);
        chk("R8 no flags", {6'b0, dev_err, crc_err}, 8'h00);
        // R2: start and byte in same cycle after a dirty code.
        send(8'h99, 0, 0);
        send(8'h5A, 0, 1);
        chk("R2 start with byte", crc_out, 8'h81);

        // Random transactions against the model (R1, R5).
        void'($urandom(32'h5EED_0001));
        for (int t = 0; t < 200; t++) begin
            int n;
            logic bad;
            n = 1 + ($urandom % 5);
            rd_dir = $urandom % 2;
            auto_en = ($urandom % 4) != 0;
            bad = $urandom % 2;
            for (int i = 0; i < n; i++) begin
                send($urandom, 0, i == 0);
                chk("R1 random crc", crc_out, m_crc);
            end
            send(bad ? (m_crc ^ 8'h80) : m_crc, 1, 0);
            chk("R5 random crc", crc_out, m_crc);
            chk("R5 random flags", {6'b0, dev_err, crc_err}, {6'b0, m_dev, m_crcf});
            if ($urandom % 3 == 0) clear_both();
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule